// File: doc/BRIEF.md
# Pipelined Burst Static Memory with Lane Writes

This block is a single-port synchronous static memory, 32 bits wide, that a bus master drives like a classic pipelined burst part. A cycle with an address strobe captures the full address. The two lowest address bits seed a 2-bit burst sequencer. Later cycles with the advance input low step through the other three words of the 4-word group, in either linear or interleaved order. Writes can cover the whole word or any set of 8-bit lanes. The old tristate data pins become a separate write bus, a read bus and a read-valid flag.

There are two address strobes. The first, the processor strobe, can only act while enable 1 is asserted, and it always starts a read. The second, the controller strobe, can also write on the cycle that loads the address. When both are low, the processor strobe wins. Three enables select the device. A strobe cycle that finds the device unselected ends the current burst.

Read data is registered, so it appears one clock after its address is formed. The output enable gates that data, except on the first cycle after a load from the deselected state, when the data stays hidden. A sleep input freezes the memory: it allows no reads or writes and keeps the contents.

Top module: `burst_sram`

## Requirements
- R1: After reset the device is deselected: `rdata_en` is 0 and `rdata` is all zeros.
- R2: A rising edge where a strobe is acted on and the device is selected (`en1_n`=0, `en2`=1, `en3_n`=0) captures `addr_i`. The word at that address is on `rdata` after that edge.
- R3: When both strobes are low and `en1_n` is 0, only the processor strobe is acted on, so that cycle writes nothing even when write enables are active.
- R4: While `en1_n` is 1 the processor strobe is ignored; with the controller strobe high, that cycle acts as an ordinary burst cycle.
- R5: A strobe acted on while the device is not selected deselects it: `rdata_en` is 0 after that edge.
- R6: With `order_il`=0, each edge with `adv_n`=0 during a burst (and no strobe) steps the low address bits up by one modulo 4 from the loaded value.
- R7: With `order_il`=1, the low address bits are the loaded value XOR the step count 0,1,2,3. After four steps the sequence returns to the start.
- R8: `wr_all_n`=0 writes all four lanes, regardless of `wr_byte_n` and `lane_n`.
- R9: Otherwise a lane is written only when `wr_byte_n`=0 and its bit of `lane_n` is 0 (bit k selects bits 8k+7..8k). With `wr_byte_n`=1 nothing is written.
- R10: A burst-cycle write goes to the current burst address before any advance. A controller-strobe write goes to the newly captured address. A read of the written word returns the new data at once.
- R11: After a load from the deselected state, `rdata_en` is 0 for one cycle.
- R12: `rdata_en` is 1 only while `oe_n` is 0. While `rdata_en` is 0, `rdata` is zero.
- R13: While `sleep` is 1 no read or write happens and the contents are kept. After sleep the device is deselected until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | AW | Word address captured on a strobe |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| en1_n | input | 1 | Select enable 1, active low, also gates processor strobe |
| en2 | input | 1 | Select enable 2, active high |
| en3_n | input | 1 | Select enable 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Lane write enable, active low |
| lane_n | input | DW/8 | Per-lane write selects, active low |
| oe_n | input | 1 | Read output enable, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Freeze: no access, contents kept |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero when not valid |
| rdata_en | output | 1 | Read data valid |

## Verification
On every cycle the assertions check the burst counter: it clears on a load, steps by one on an advance and holds otherwise. They also check that deselecting strobes, sleep and loads from the deselected state suppress `rdata_en` on the following cycle. The data itself can only be shown by the bench scenarios, which include the exact linear and interleaved word sequences, lane-merged write results, the strobe priority dropping a write, contents surviving sleep, and a long random mix compared against a reference model.

// File: rtl/sram_pkg.sv
package sram_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    localparam int LANE_W = 8;
endpackage

// File: rtl/burst_step.sv
module burst_step
    import sram_pkg::*;
(
    input  logic [1:0] start_i,
    input  logic [1:0] count_i,
    input  logic       order_i,
    output logic [1:0] low_o
);
    // low address bits of the burst word selected by the step count
    always_comb begin
        if (order_i == ORD_INTERLEAVE) low_o = start_i ^ count_i;
        else                           low_o = start_i + count_i;
    end
endmodule

// File: rtl/lane_mask.sv
module lane_mask #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] en_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign en_o[g] = !wr_all_n || (!wr_byte_n && !lane_n[g]);
    end
endmodule

// File: rtl/sram_store.sv
module sram_store
    import sram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 we_i,
    input  logic [DW/LANE_W-1:0] lanes_i,
    input  logic [AW-1:0]        waddr_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [AW-1:0]        raddr_i,
    output logic [DW-1:0]        rdata_o
);
    localparam int DEPTH = 1 << AW;
    localparam int LANES = DW / LANE_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (lanes_i[l]) mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import sram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr_i,
    input  logic                 strb_cpu_n,
    input  logic                 strb_ctl_n,
    input  logic                 en1_n,
    input  logic                 en2,
    input  logic                 en3_n,
    input  logic                 adv_n,
    input  logic                 wr_all_n,
    input  logic                 wr_byte_n,
    input  logic [DW/8-1:0]      lane_n,
    input  logic                 oe_n,
    input  logic                 order_il,
    input  logic                 sleep,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic                 rdata_en
);
    localparam int LANES = DW / LANE_W;
    localparam int BW    = AW - 2;

    typedef struct packed {
        logic          active;
        logic          hide;
        logic [BW-1:0] base;
        logic [1:0]    start;
        logic [1:0]    count;
        logic [DW-1:0] rd;
    } state_t;

    state_t s_d, s_q;

    logic             sel_ok, cpu_go, ctl_go, strobe_hit, load, ctl_load;
    logic [BW-1:0]    base_n;
    logic [1:0]       start_n, count_n, cur_low, nxt_low;
    logic [AW-1:0]    cur_addr, nxt_addr, waddr;
    logic [LANES-1:0] wr_lanes;
    logic             we;
    logic [DW-1:0]    mem_rd, merged;

    // strobe decode and priority
    assign sel_ok     = !en1_n && en2 && !en3_n;
    assign cpu_go     = !strb_cpu_n && !en1_n;
    assign ctl_go     = !cpu_go && !strb_ctl_n;
    assign strobe_hit = cpu_go || ctl_go;
    assign load       = strobe_hit && sel_ok && !sleep;
    assign ctl_load   = ctl_go && sel_ok && !sleep;

    burst_step u_cur (
        .start_i (s_q.start),
        .count_i (s_q.count),
        .order_i (order_il),
        .low_o   (cur_low)
    );

    // next burst pointer
    always_comb begin
        base_n  = s_q.base;
        start_n = s_q.start;
        count_n = s_q.count;
        if (load) begin
            base_n  = addr_i[AW-1:2];
            start_n = addr_i[1:0];
            count_n = 2'd0;
        end else if (!sleep && !strobe_hit && s_q.active && !adv_n) begin
            count_n = s_q.count + 2'd1;
        end
    end

    burst_step u_nxt (
        .start_i (start_n),
        .count_i (count_n),
        .order_i (order_il),
        .low_o   (nxt_low)
    );

    assign cur_addr = {s_q.base, cur_low};
    assign nxt_addr = {base_n, nxt_low};

    lane_mask #(.LANES(LANES)) u_mask (
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_n    (lane_n),
        .en_o      (wr_lanes)
    );

    assign we    = !sleep && (ctl_load || (s_q.active && !strobe_hit)) && (|wr_lanes);
    assign waddr = ctl_load ? addr_i : cur_addr;

    sram_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .we_i    (we),
        .lanes_i (wr_lanes),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (nxt_addr),
        .rdata_o (mem_rd)
    );

    // forward bytes written this cycle into the registered read word
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign merged[g*LANE_W +: LANE_W] =
            (we && wr_lanes[g] && (waddr == nxt_addr)) ? wdata[g*LANE_W +: LANE_W]
                                                       : mem_rd[g*LANE_W +: LANE_W];
    end

    always_comb begin
        s_d      = s_q;
        s_d.hide = 1'b0;
        if (sleep) begin
            s_d.active = 1'b0;
        end else begin
            if (strobe_hit) begin
                s_d.active = sel_ok;
                s_d.hide   = sel_ok && !s_q.active;
            end
            s_d.base  = base_n;
            s_d.start = start_n;
            s_d.count = count_n;
            s_d.rd    = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata_en = s_q.active && !s_q.hide && !oe_n && !sleep;
    assign rdata    = rdata_en ? s_q.rd : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep,
    input logic       en1_n,
    input logic       en2,
    input logic       en3_n,
    input logic       adv_n,
    input logic       hit,
    input logic       active_q,
    input logic [1:0] count_q,
    input logic       rdata_en
);
    logic sel;
    assign sel = !en1_n && en2 && !en3_n;

    // R11: a load from the deselected state hides the first read cycle
    a_r11_first_read_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && hit && sel && !active_q) |=> !rdata_en);

    // R5: a strobe without selection ends the burst
    a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && hit && !sel) |=> !rdata_en);

    // R13: sleeping leaves the device deselected
    a_r13_wake_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rdata_en);

    // R2: a load restarts the step count
    a_r2_load_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && hit && sel) |=> (count_q == 2'd0));

    // R6: advance steps the count by one, modulo 4
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !hit && active_q && !adv_n) |=> (count_q == $past(count_q) + 2'd1));

    // R6: no advance keeps the count
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !hit && adv_n) |=> $stable(count_q));
endmodule

bind burst_sram burst_sram_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .en1_n    (en1_n),
    .en2      (en2),
    .en3_n    (en3_n),
    .adv_n    (adv_n),
    .hit      (strobe_hit),
    .active_q (s_q.active),
    .count_q  (s_q.count),
    .rdata_en (rdata_en)
);

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;
    localparam int AW = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic          strb_cpu_n, strb_ctl_n, en1_n, en2, en3_n, adv_n;
    logic          wr_all_n, wr_byte_n, oe_n, order_il, sleep;
    logic [3:0]    lane_n;
    logic [DW-1:0] wdata, rdata;
    logic          rdata_en;

    int checks = 0;
    int errors = 0;
    string tag = "R2";

    always #10 clk = ~clk;

    burst_sram #(.AW(AW), .DW(DW)) dut (.*);

    // reference model
    logic [DW-1:0] mm [1<<AW];
    logic          m_act, m_hide;
    logic [AW-3:0] m_base;
    logic [1:0]    m_st, m_cnt;
    logic [DW-1:0] m_rd;

    function automatic logic [1:0] low_of(logic [1:0] s, logic [1:0] c, logic il);
        return il ? (s ^ c) : (s + c);
    endfunction

    function automatic logic [DW-1:0] pat(int a);
        return 32'hA500_0000 | a;
    endfunction

    task automatic model_edge();
        logic sel, cpu, ctl, hit;
        logic [3:0] ln;
        logic [AW-1:0] wa;
        logic wr;
        sel = !en1_n && en2 && !en3_n;
        cpu = !strb_cpu_n && !en1_n;
        ctl = !cpu && !strb_ctl_n;
        hit = cpu || ctl;
        if (!rst_n) begin
            m_act = 0; m_hide = 0; m_base = '0; m_st = 0; m_cnt = 0; m_rd = '0;
        end else if (sleep) begin
            m_act = 0; m_hide = 0;
        end else begin
            ln = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_n : 4'h0);
            wr = (ctl && sel) || (m_act && !hit);
            wa = (ctl && sel) ? addr_i : {m_base, low_of(m_st, m_cnt, order_il)};
            if (wr) for (int l = 0; l < 4; l++) if (ln[l]) mm[wa][l*8 +: 8] = wdata[l*8 +: 8];
            if (hit) begin
                m_hide = sel && !m_act;
                m_act  = sel;
                if (sel) begin m_base = addr_i[AW-1:2]; m_st = addr_i[1:0]; m_cnt = 0; end
            end else begin
                m_hide = 0;
                if (m_act && !adv_n) m_cnt = m_cnt + 1;
            end
            m_rd = mm[{m_base, low_of(m_st, m_cnt, order_il)}];
        end
    endtask

    task automatic chk(string t, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic tick();
        logic e;
        @(posedge clk);
        model_edge();
        #2;
        e = m_act && !m_hide && !oe_n && !sleep;
        chk({tag, " rdata_en"}, {31'd0, rdata_en}, {31'd0, e});
        chk({tag, " rdata"}, rdata, e ? m_rd : '0);
    endtask

    task automatic idle();
        strb_cpu_n = 1; strb_ctl_n = 1; en1_n = 0; en2 = 1; en3_n = 0; adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; oe_n = 0; sleep = 0;
    endtask

    task automatic load_ctl(int a);
        idle(); strb_ctl_n = 0; addr_i = AW'(a); tick(); idle();
    endtask

    task automatic deselect();
        idle(); strb_ctl_n = 0; en2 = 0; tick(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mm[i] = '0;
        idle(); rst_n = 0; order_il = 0; addr_i = '0; wdata = '0;
        repeat (3) @(posedge clk);
        model_edge();
        #2 rst_n = 1;
        // R1: reset state
        chk("R1 rdata_en", {31'd0, rdata_en}, 32'd0);
        chk("R1 rdata", rdata, '0);

        // prefill words 0..63 with linear bursts of whole-word writes (R8, R10)
        tag = "R8";
        for (int b = 0; b < 16; b++) begin
            load_ctl(b * 4);
            for (int k = 0; k < 4; k++) begin
                wr_all_n = 0; adv_n = 0; wdata = pat(b * 4 + k); tick();
            end
            idle();
        end

        // R7 + R11: interleaved burst from start 6 after deselect
        tag = "R7";
        deselect();
        order_il = 1; strb_cpu_n = 0; addr_i = 6; tick(); idle();
        chk("R11 hidden first cycle", {31'd0, rdata_en}, 32'd0);
        tick();
        chk("R7 word 6", rdata, pat(6));
        adv_n = 0; tick(); chk("R7 word 7", rdata, pat(7));
        tick(); chk("R7 word 4", rdata, pat(4));
        tick(); chk("R7 word 5", rdata, pat(5));
        tick(); chk("R7 wrap word 6", rdata, pat(6));
        idle();

        // R6: linear burst from start 6 while active (no hiding)
        tag = "R6";
        order_il = 0; strb_cpu_n = 0; addr_i = 6; tick(); idle();
        chk("R6 word 6", rdata, pat(6));
        adv_n = 0; tick(); chk("R6 word 7", rdata, pat(7));
        tick(); chk("R6 word 4", rdata, pat(4));
        tick(); chk("R6 word 5", rdata, pat(5));
        idle();

        // R9 / R8 / R10: lane writes at word 9
        tag = "R9";
        load_ctl(9);
        wr_byte_n = 0; lane_n = 4'b1010; wdata = 32'h1122_3344; tick(); idle();
        chk("R9 lanes 0 and 2", rdata, 32'hA522_0044);
        wr_byte_n = 1; lane_n = 4'h0; wdata = 32'hFFFF_FFFF; tick(); idle();
        chk("R9 no byte enable", rdata, 32'hA522_0044);
        wr_all_n = 0; wr_byte_n = 1; lane_n = 4'hF; wdata = 32'hDEAD_BEEF; tick(); idle();
        chk("R8 global write", rdata, 32'hDEAD_BEEF);

        // R3: both strobes low -> processor wins, no write
        tag = "R3";
        strb_cpu_n = 0; strb_ctl_n = 0; addr_i = 20; wr_all_n = 0; wdata = 32'h0BAD_0BAD; tick(); idle();
        chk("R3 no write on processor load", rdata, pat(20));
        strb_ctl_n = 0; addr_i = 21; wr_all_n = 0; wdata = 32'h1234_5678; tick(); idle();
        chk("R10 controller load writes", rdata, 32'h1234_5678);

        // R4: processor strobe with en1_n high is ignored, burst continues
        tag = "R4";
        load_ctl(32);
        strb_cpu_n = 0; en1_n = 1; addr_i = 40; adv_n = 0; tick(); idle();
        chk("R4 burst continued", rdata, pat(33));

        // R5: strobe with en3_n high deselects
        tag = "R5";
        strb_ctl_n = 0; en3_n = 1; addr_i = 8; tick(); idle();
        chk("R5 deselected", {31'd0, rdata_en}, 32'd0);

        // R13: sleep blocks access and keeps contents
        tag = "R13";
        load_ctl(12); tick();
        sleep = 1; wr_all_n = 0; strb_ctl_n = 0; addr_i = 12; wdata = 32'h5555_AAAA; tick(); tick();
        chk("R13 no read in sleep", {31'd0, rdata_en}, 32'd0);
        idle(); tick();
        chk("R13 deselected after wake", {31'd0, rdata_en}, 32'd0);
        strb_cpu_n = 0; addr_i = 12; tick(); idle(); tick();
        chk("R13 contents kept", rdata, pat(12));

        // R12: output enable gates data
        tag = "R12";
        oe_n = 1; tick();
        chk("R12 oe high hides", {31'd0, rdata_en}, 32'd0);
        chk("R12 zero data", rdata, '0);
        idle();

        // random mix against the model
        tag = "R2";
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            if (n == 2000) order_il = 1;
            strb_cpu_n = ($urandom % 8) != 0;
            strb_ctl_n = ($urandom % 8) != 0;
            en1_n      = ($urandom % 16) == 0;
            en2        = ($urandom % 16) != 0;
            en3_n      = ($urandom % 16) == 0;
            adv_n      = $urandom % 2;
            wr_all_n   = ($urandom % 8) != 0;
            wr_byte_n  = ($urandom % 4) != 0;
            lane_n     = 4'($urandom);
            oe_n       = ($urandom % 4) == 0;
            sleep      = ($urandom % 32) == 0;
            addr_i     = AW'($urandom % 64);
            wdata      = $urandom;
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule